// File: doc/BRIEF.md
# Automaton Frame Sequencer

This block paces a column-parallel cellular-automaton grid of 640 by 480 cells so that grid updates follow the raster scan of the display. The display timing generator reports the start of each frame and the end of each rendered visible row. On an update frame, every row-complete event is turned, one cycle later, into a single compute strobe that all column engines receive at once, together with the index of the row to compute.

A frame-skip setting thins out the updates: with setting N, one frame in N+1 is computed, which gives 60, 30, 20, 15 Hz and so on from a 60 Hz display. The run input is a request. The running output changes only at frame boundaries, so a stop request lets the current frame finish. While the sequencer is halted, a host can write single cells through an asynchronous strobe port. The strobe is synchronised and edge-detected, and each pulse yields exactly one cell-write request toward the grid memory.

Top module: `life_frame_sequencer`

## Requirements
- R1: After reset, running_o, row_stb_o and wr_en_o are all 0, and row-complete events cause no strobes until a frame has been started.
- R2: On an update frame, the k-th line_done_i pulse after frame_start_i (k counted from 0) drives row_stb_o high for one cycle in the following cycle, with row_idx_o equal to k.
- R3: line_done_i pulses beyond the 480th in a frame produce no strobe, and row_idx_o never reaches 480.
- R4: With skip setting N held, frames are updated in the pattern one updated, then N skipped, repeated. The first frame after running rises is always updated.
- R5: The skip setting is sampled only when an updated frame begins. A new value that is applied during skipped frames does not shorten the countdown already in progress.
- R6: When run_i is low at a frame_start_i, running_o falls in the next cycle. Rows of the frame in progress when run_i fell keep being strobed up to the end of that frame, and no strobe follows.
- R7: When run_i is high at a frame_start_i while halted, running_o rises in the next cycle. That frame is updated from row 0.
- R8: While running_o is low, a rising edge on host_stb_i gives exactly one wr_en_o pulse SYNC_STAGES+1 cycles later. The pulse carries host_x_i, host_y_i and host_data_i.
- R9: Host strobe edges that occur while running_o is high produce no wr_en_o pulse.
- R10: A host strobe held high for many cycles produces only one write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run request, acted on at frame boundaries |
| skip_i | input | SKIP_W | Number of frames skipped after each updated frame |
| frame_start_i | input | 1 | One-cycle pulse at the start of a display frame |
| line_done_i | input | 1 | One-cycle pulse when the display finishes a row |
| host_x_i | input | XW | Host write column |
| host_y_i | input | YW | Host write row |
| host_data_i | input | DATA_W | Host write cell value |
| host_stb_i | input | 1 | Asynchronous host data-ready strobe |
| running_o | output | 1 | Grid is being sequenced |
| row_stb_o | output | 1 | Broadcast compute strobe to all column engines |
| row_idx_o | output | YW | Row to compute with row_stb_o |
| wr_en_o | output | 1 | Single-cell write request |
| wr_x_o | output | XW | Write column |
| wr_y_o | output | YW | Write row |
| wr_data_o | output | DATA_W | Write value |

## Verification
The bench drives whole frames that contain two extra row events. A design that does not bound the row count would strobe rows 480 and 481. Skip settings of 2 and 0 are applied between frames and in the middle of a countdown. An off-by-one counter gives the wrong update pattern, and a design that samples the setting continuously would update a frame too early. Run is dropped halfway through a frame. A sequencer that stops at once loses the remaining rows, and one that stops late strobes the next frame. Host strobes are held long and are also raised while running, to catch repeated writes and writes that leak through the gate.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

   typedef enum logic {
      SEQ_HALTED = 1'b0,
      SEQ_ACTIVE = 1'b1
   } seq_state_t;

   // bits needed to hold the value n itself
   function automatic int unsigned span_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/lfs_frame_ctrl.sv
module lfs_frame_ctrl
   import lfs_pkg::*;
#(
   parameter int unsigned SKIP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [SKIP_W-1:0] skip_i,
   input  logic              frame_start_i,
   output logic              running_o,
   output logic              upd_o
);

   seq_state_t        state_q;
   logic [SKIP_W-1:0] skip_left_q;
   logic              upd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= SEQ_HALTED;
         skip_left_q <= '0;
         upd_q       <= 1'b0;
      end else if (frame_start_i) begin
         unique case (state_q)
            SEQ_HALTED: begin
               if (run_i) begin
                  state_q     <= SEQ_ACTIVE;
                  upd_q       <= 1'b1;
                  skip_left_q <= skip_i;
               end
            end
            SEQ_ACTIVE: begin
               if (!run_i) begin
                  state_q <= SEQ_HALTED;
                  upd_q   <= 1'b0;
               end else if (skip_left_q == '0) begin
                  upd_q       <= 1'b1;
                  skip_left_q <= skip_i;
               end else begin
                  upd_q       <= 1'b0;
                  skip_left_q <= skip_left_q - 1'b1;
               end
            end
            default: state_q <= SEQ_HALTED;
         endcase
      end
   end

   assign running_o = (state_q == SEQ_ACTIVE);
   assign upd_o     = upd_q;

   p_rise_on_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running_o) |-> $past(frame_start_i && run_i));

   p_fall_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running_o) |-> $past(frame_start_i && !run_i));

   p_update_needs_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |-> running_o);

   p_update_moves_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(upd_o) |-> $past(frame_start_i));

endmodule

// File: rtl/lfs_row_issue.sv
module lfs_row_issue
   import lfs_pkg::*;
#(
   parameter int unsigned ROWS = 480,
   localparam int unsigned YW  = $clog2(ROWS),
   localparam int unsigned RCW = span_w(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start_i,
   input  logic          line_done_i,
   input  logic          upd_i,
   output logic          row_stb_o,
   output logic [YW-1:0] row_idx_o
);

   logic [RCW-1:0] row_cnt_q;
   logic           in_grid;

   assign in_grid = (row_cnt_q < RCW'(ROWS));

   // frame start wins over a coincident row event
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_cnt_q <= '0;
         row_stb_o <= 1'b0;
         row_idx_o <= '0;
      end else begin
         row_stb_o <= 1'b0;
         if (frame_start_i) begin
            row_cnt_q <= '0;
         end else if (line_done_i && in_grid) begin
            row_cnt_q <= row_cnt_q + 1'b1;
            if (upd_i) begin
               row_stb_o <= 1'b1;
               row_idx_o <= row_cnt_q[YW-1:0];
            end
         end
      end
   end

   p_strobe_from_row_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
      row_stb_o |-> $past(line_done_i && !frame_start_i && upd_i));

   p_index_in_grid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      row_stb_o |-> (32'(row_idx_o) < ROWS));

   p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (row_stb_o && !line_done_i) |=> !row_stb_o);

endmodule

// File: rtl/lfs_host_port.sv
module lfs_host_port #(
   parameter int unsigned XW          = 10,
   parameter int unsigned YW          = 9,
   parameter int unsigned DATA_W      = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running_i,
   input  logic [XW-1:0]     host_x_i,
   input  logic [YW-1:0]     host_y_i,
   input  logic [DATA_W-1:0] host_data_i,
   input  logic              host_stb_i,
   output logic              wr_en_o,
   output logic [XW-1:0]     wr_x_o,
   output logic [YW-1:0]     wr_y_o,
   output logic [DATA_W-1:0] wr_data_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   stb_rise;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= host_stb_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign stb_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en_o   <= 1'b0;
         wr_x_o    <= '0;
         wr_y_o    <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= stb_rise & ~running_i;
         if (stb_rise & ~running_i) begin
            wr_x_o    <= host_x_i;
            wr_y_o    <= host_y_i;
            wr_data_o <= host_data_i;
         end
      end
   end

   p_one_write_per_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   p_no_write_while_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !$past(running_i));

endmodule

// File: rtl/life_frame_sequencer.sv
module life_frame_sequencer
   import lfs_pkg::*;
#(
   parameter int unsigned COLS        = 640,
   parameter int unsigned ROWS        = 480,
   parameter int unsigned DATA_W      = 1,
   parameter int unsigned SKIP_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned XW         = $clog2(COLS),
   localparam int unsigned YW         = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [SKIP_W-1:0] skip_i,
   input  logic              frame_start_i,
   input  logic              line_done_i,
   input  logic [XW-1:0]     host_x_i,
   input  logic [YW-1:0]     host_y_i,
   input  logic [DATA_W-1:0] host_data_i,
   input  logic              host_stb_i,
   output logic              running_o,
   output logic              row_stb_o,
   output logic [YW-1:0]     row_idx_o,
   output logic              wr_en_o,
   output logic [XW-1:0]     wr_x_o,
   output logic [YW-1:0]     wr_y_o,
   output logic [DATA_W-1:0] wr_data_o
);

   if (COLS < 2 || ROWS < 2) begin : g_bad_grid
      $error("life_frame_sequencer: grid must be at least 2x2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("life_frame_sequencer: SYNC_STAGES must be 2 or more");
   end
   if (SKIP_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("life_frame_sequencer: SKIP_W and DATA_W must be positive");
   end

   logic upd;

   lfs_frame_ctrl #(
      .SKIP_W (SKIP_W)
   ) u_frame (
      .clk           (clk),
      .rst_n         (rst_n),
      .run_i         (run_i),
      .skip_i        (skip_i),
      .frame_start_i (frame_start_i),
      .running_o     (running_o),
      .upd_o         (upd)
   );

   lfs_row_issue #(
      .ROWS (ROWS)
   ) u_rows (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start_i),
      .line_done_i   (line_done_i),
      .upd_i         (upd),
      .row_stb_o     (row_stb_o),
      .row_idx_o     (row_idx_o)
   );

   lfs_host_port #(
      .XW          (XW),
      .YW          (YW),
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_host (
      .clk         (clk),
      .rst_n       (rst_n),
      .running_i   (running_o),
      .host_x_i    (host_x_i),
      .host_y_i    (host_y_i),
      .host_data_i (host_data_i),
      .host_stb_i  (host_stb_i),
      .wr_en_o     (wr_en_o),
      .wr_x_o      (wr_x_o),
      .wr_y_o      (wr_y_o),
      .wr_data_o   (wr_data_o)
   );

   p_reset_quiet_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> (!running_o && !row_stb_o && !wr_en_o));

endmodule

// File: tb/tb_life_frame_sequencer.sv
module tb_life_frame_sequencer;

   localparam int ROWS = 480;
   localparam int LAT  = 3;   // SYNC_STAGES + 1

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic [3:0] skip = '0;
   logic       fs = 1'b0;
   logic       ld = 1'b0;
   logic [9:0] hx = '0;
   logic [8:0] hy = '0;
   logic [0:0] hd = '0;
   logic       hstb = 1'b0;
   logic       running, row_stb, wr_en;
   logic [8:0] row_idx, wr_y;
   logic [9:0] wr_x;
   logic [0:0] wr_d;

   int nchecks = 0;
   int nfail   = 0;
   int nwrites = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   life_frame_sequencer dut (
      .clk(clk), .rst_n(rst_n), .run_i(run), .skip_i(skip),
      .frame_start_i(fs), .line_done_i(ld),
      .host_x_i(hx), .host_y_i(hy), .host_data_i(hd), .host_stb_i(hstb),
      .running_o(running), .row_stb_o(row_stb), .row_idx_o(row_idx),
      .wr_en_o(wr_en), .wr_x_o(wr_x), .wr_y_o(wr_y), .wr_data_o(wr_d)
   );

   always @(negedge clk) if (wr_en) nwrites++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
         $finish;
      end
   endtask

   // one display frame with ROWS+2 row events; drop_at < 0 keeps run as is
   task automatic do_frame(input bit expect_upd, input string req, input int drop_at);
      int bad = 0;
      int first_bad = -1;
      @(negedge clk) fs = 1'b1;
      @(negedge clk) fs = 1'b0;
      for (int r = 0; r < ROWS + 2; r++) begin
         bit exp;
         if (r == drop_at) run = 1'b0;
         @(negedge clk) ld = 1'b1;
         @(negedge clk) ld = 1'b0;
         exp = expect_upd && (r < ROWS);
         if (row_stb !== exp || (exp && int'(row_idx) != r)) begin
            bad++;
            if (first_bad < 0) first_bad = r;
         end
         @(negedge clk);
         if (row_stb !== 1'b0) bad++;
      end
      check(bad == 0, req, first_bad, -1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(running == 1'b0, "R1 running after reset", running, 0);
      check(row_stb == 1'b0, "R1 row strobe after reset", row_stb, 0);
      check(wr_en == 1'b0, "R1 write after reset", wr_en, 0);
      do_frame(1'b0, "R1 no strobes while halted", -1);
      check(running == 1'b0, "R1 still halted", running, 0);
   endtask

   task automatic t_host_write_idle();
      int base;
      int seen_at = -1;
      base = nwrites;
      @(negedge clk);
      hx = 10'd613; hy = 9'd377; hd = 1'b1; hstb = 1'b1;
      for (int c = 1; c <= 12; c++) begin
         @(negedge clk);
         if (wr_en && seen_at < 0) seen_at = c;
      end
      check(seen_at == LAT, "R8 write latency", seen_at, LAT);
      check(nwrites - base == 1, "R10 held strobe writes once", nwrites - base, 1);
      check(int'(wr_x) == 613 && int'(wr_y) == 377 && wr_d == 1'b1,
            "R8 write fields", int'(wr_x) * 1000 + int'(wr_y), 613377);
      hstb = 1'b0;
      repeat (4) @(negedge clk);
      // second pulse, different values
      hx = 10'd0; hy = 9'd479; hd = 1'b0; hstb = 1'b1;
      @(negedge clk) hstb = 1'b0;
      repeat (6) @(negedge clk);
      check(nwrites - base == 2, "R8 second pulse writes", nwrites - base, 2);
      check(int'(wr_x) == 0 && int'(wr_y) == 479 && wr_d == 1'b0,
            "R8 second write fields", int'(wr_x) * 1000 + int'(wr_y), 479);
   endtask

   task automatic t_start();
      run = 1'b1; skip = 4'd0;
      @(negedge clk);
      check(running == 1'b0, "R7 no start before boundary", running, 0);
      do_frame(1'b1, "R7 R2 R3 first frame updated from row 0", -1);
      check(running == 1'b1, "R7 running after boundary", running, 1);
   endtask

   task automatic t_host_while_running();
      int base;
      base = nwrites;
      @(negedge clk);
      hx = 10'd5; hy = 9'd5; hd = 1'b1; hstb = 1'b1;
      repeat (8) @(negedge clk);
      hstb = 1'b0;
      repeat (4) @(negedge clk);
      check(nwrites == base, "R9 write blocked while running", nwrites - base, 0);
      check(int'(wr_x) == 0 && int'(wr_y) == 479, "R9 write fields untouched",
            int'(wr_x), 0);
   endtask

   task automatic t_skip();
      skip = 4'd2;
      do_frame(1'b1, "R4 counter at zero updates", -1);
      skip = 4'd0;
      do_frame(1'b0, "R5 countdown kept first skip", -1);
      do_frame(1'b0, "R5 countdown kept second skip", -1);
      do_frame(1'b1, "R4 update after two skips", -1);
      do_frame(1'b1, "R4 skip zero updates every frame", -1);
   endtask

   task automatic t_stop();
      do_frame(1'b1, "R6 frame finishes after run drops", ROWS / 2);
      check(running == 1'b1, "R6 running held to boundary", running, 1);
      do_frame(1'b0, "R6 no strobes after stop", -1);
      check(running == 1'b0, "R6 running low after boundary", running, 0);
   endtask

   task automatic t_restart();
      int base;
      base = nwrites;
      hx = 10'd320; hy = 9'd240; hd = 1'b1; hstb = 1'b1;
      repeat (6) @(negedge clk);
      hstb = 1'b0;
      check(nwrites - base == 1, "R8 write accepted after stop", nwrites - base, 1);
      run = 1'b1; skip = 4'd1;
      do_frame(1'b1, "R7 restart updates from row 0", -1);
      do_frame(1'b0, "R4 skip one", -1);
      do_frame(1'b1, "R4 update after one skip", -1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchecks++;
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_host_write_idle();
      t_start();
      t_host_while_running();
      t_skip();
      t_stop();
      t_restart();
      finish_run();
   end

endmodule